// File: doc/BRIEF.md
# Packed SIMD Halving Adder

This unit adds or subtracts two 32-bit operands treated as packed lanes. It then stores the outcome in a result register on a clock edge where the input is qualified as valid. A 4-bit operation code selects one of four lane layouts:

- two unsigned 16-bit lanes, with wrap-around or clamping;
- four unsigned 8-bit lanes that halve their sum or difference;
- two signed 16-bit lanes that halve;
- one signed full-width lane that halves.

Each halving form can optionally round half up before the shift. Only the unsigned 16-bit forms can report overflow. They raise a one-cycle overflow pulse alongside the stored result. A sticky flag collects those pulses until a clear input is asserted.

The unit is meant to sit behind an operand-read stage. It accepts operands and a code in one cycle and presents the result one clock later.

Top module: `simd_half_alu`

## Requirements
- R1: While reset is high, and in the cycle after it is released, the result, the overflow pulse and the sticky flag are all zero.
- R2: The code is decoded by fields. Bits [3:2] select the family: 0 = unsigned 16-bit, 1 = unsigned byte halving, 2 = signed 16-bit halving, 3 = signed 32-bit halving. Bit 1 selects subtract (1) or add (0). Bit 0 selects clamping in family 0 and rounding in the others. 16-bit lane k occupies bits [16k+15:16k], and byte lane k occupies bits [8k+7:8k].
- R3: An unsigned 16-bit add whose true lane sum exceeds 0xFFFF raises overflow. That lane holds 0xFFFF when bit 0 is set, and the low 16 bits of the sum otherwise.
- R4: An unsigned 16-bit subtract with the first lane below the second raises overflow. That lane holds 0x0000 when bit 0 is set, and the wrapped difference otherwise.
- R5: In byte halving, each lane result is floor((x ± y + r) / 2) taken modulo 256, where r is bit 0. For subtract this equals bits [8:1] of the two's-complement difference.
- R6: In signed 16-bit halving, each lane result is the arithmetic floor of (x ± y + r) / 2, keeping the low 16 bits.
- R7: In signed 32-bit halving, the result is the arithmetic floor of (x ± y + r) / 2, computed without loss.
- R8: The three halving families never raise the overflow pulse.
- R9: The result and pulse update only on an edge with valid high. On an edge with valid low, the result holds and the pulse is zero.
- R10: The sticky flag becomes 1 when an overflow is captured and stays 1 until clear is sampled high. If clear and a new overflow arrive on the same edge, clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Captures the operation on this edge |
| op_code | input | 4 | Family, subtract and clamp/round fields |
| opnd_a | input | 32 | First operand (minuend) |
| opnd_b | input | 32 | Second operand (subtrahend) |
| clr_sticky | input | 1 | Clears the sticky overflow flag |
| result | output | 32 | Registered packed result |
| ovf_pulse | output | 1 | Overflow of the last captured operation |
| ovf_sticky | output | 1 | Accumulated overflow since the last clear |

## Verification
The assertions assume that clear, valid and the code are sampled only on rising edges. They also assume a single capture per edge, and make no assumption about operand values, so any code or data is legal. The stimulus changes inputs only on falling edges. It walks every code over a grid of lane corner values (zero, all ones, sign boundaries, unit values) plus random pairs. Clear is inserted both alone and on the same edge as a clamping overflow.

// File: rtl/simd_half_pkg.sv
package simd_half_pkg;

    localparam int OP_W   = 4;
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        FAM_UHALF  = 2'd0,
        FAM_UBYTEH = 2'd1,
        FAM_SHALFH = 2'd2,
        FAM_SWORDH = 2'd3
    } family_e;

    typedef struct packed {
        family_e fam;
        logic    sub;
        logic    modf;   // clamp in FAM_UHALF, round elsewhere
    } op_fields_t;

    function automatic op_fields_t decode_op(input logic [OP_W-1:0] code);
        op_fields_t f;
        f.fam  = family_e'(code[3:2]);
        f.sub  = code[1];
        f.modf = code[0];
        return f;
    endfunction

endpackage

// File: rtl/simd_uh_lane.sv
module simd_uh_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         clamp,
    output logic [W-1:0] y,
    output logic         ovf
);
    logic [W:0] wide;

    always_comb begin
        if (sub) wide = {1'b0, a} - {1'b0, b};
        else     wide = {1'b0, a} + {1'b0, b};
        // carry out on add, borrow out on subtract
        ovf = wide[W];
        y   = wide[W-1:0];
        if (ovf && clamp) y = sub ? '0 : '1;
    end
endmodule

// File: rtl/simd_halve_lane.sv
module simd_halve_lane #(
    parameter int W      = 8,
    parameter bit SIGNED = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         rnd,
    output logic [W-1:0] y
);
    localparam int EW = W + 2;

    logic [EW-1:0] ea, eb, t;
    logic          unused_bits;

    generate
        if (SIGNED) begin : g_sext
            assign ea = {{2{a[W-1]}}, a};
            assign eb = {{2{b[W-1]}}, b};
        end else begin : g_zext
            assign ea = {2'b00, a};
            assign eb = {2'b00, b};
        end
    endgenerate

    always_comb begin
        t = (sub ? (ea - eb) : (ea + eb)) + EW'(rnd);
        y = t[W:1];
    end

    assign unused_bits = ^{t[EW-1], t[0]};
endmodule

// File: rtl/simd_half_alu.sv
module simd_half_alu
    import simd_half_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              clr_sticky,
    output logic [DATA_W-1:0] result,
    output logic              ovf_pulse,
    output logic              ovf_sticky
);
    localparam int N_HALF = DATA_W / HALF_W;
    localparam int N_BYTE = DATA_W / BYTE_W;

    op_fields_t        dec;
    logic [DATA_W-1:0] uh_y, ub_y, sh_y, sw_y;
    logic [N_HALF-1:0] uh_ovf;
    logic [DATA_W-1:0] nxt_res;
    logic              nxt_ovf;

    assign dec = decode_op(op_code);

    generate
        for (genvar h = 0; h < N_HALF; h++) begin : g_half
            simd_uh_lane #(.W(HALF_W)) u_uh (
                .a     (opnd_a[h*HALF_W +: HALF_W]),
                .b     (opnd_b[h*HALF_W +: HALF_W]),
                .sub   (dec.sub),
                .clamp (dec.modf),
                .y     (uh_y[h*HALF_W +: HALF_W]),
                .ovf   (uh_ovf[h])
            );
            simd_halve_lane #(.W(HALF_W), .SIGNED(1'b1)) u_sh (
                .a   (opnd_a[h*HALF_W +: HALF_W]),
                .b   (opnd_b[h*HALF_W +: HALF_W]),
                .sub (dec.sub),
                .rnd (dec.modf),
                .y   (sh_y[h*HALF_W +: HALF_W])
            );
        end
        for (genvar k = 0; k < N_BYTE; k++) begin : g_byte
            simd_halve_lane #(.W(BYTE_W), .SIGNED(1'b0)) u_ub (
                .a   (opnd_a[k*BYTE_W +: BYTE_W]),
                .b   (opnd_b[k*BYTE_W +: BYTE_W]),
                .sub (dec.sub),
                .rnd (dec.modf),
                .y   (ub_y[k*BYTE_W +: BYTE_W])
            );
        end
    endgenerate

    simd_halve_lane #(.W(DATA_W), .SIGNED(1'b1)) u_sw (
        .a   (opnd_a),
        .b   (opnd_b),
        .sub (dec.sub),
        .rnd (dec.modf),
        .y   (sw_y)
    );

    always_comb begin
        nxt_ovf = 1'b0;
        unique case (dec.fam)
            FAM_UHALF: begin
                nxt_res = uh_y;
                nxt_ovf = |uh_ovf;
            end
            FAM_UBYTEH: nxt_res = ub_y;
            FAM_SHALFH: nxt_res = sh_y;
            default:    nxt_res = sw_y;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result     <= '0;
            ovf_pulse  <= 1'b0;
            ovf_sticky <= 1'b0;
        end else begin
            ovf_pulse <= in_valid & nxt_ovf;
            if (in_valid) result <= nxt_res;
            if (clr_sticky)               ovf_sticky <= 1'b0;
            else if (in_valid && nxt_ovf) ovf_sticky <= 1'b1;
        end
    end
endmodule

// File: rtl/simd_half_alu_chk.sv
module simd_half_alu_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [3:0]        op_code,
    input logic              clr_sticky,
    input logic [DATA_W-1:0] result,
    input logic              ovf_pulse,
    input logic              ovf_sticky
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (result == '0 && !ovf_pulse && !ovf_sticky)); // R1

    AST_HALVING_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code[3:2] != 2'd0) |=> !ovf_pulse); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && !ovf_pulse)); // R9

    AST_STICKY_CATCHES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !clr_sticky) |=> (ovf_pulse |-> ovf_sticky)); // R10

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr_sticky |=> !ovf_sticky); // R10

    AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (ovf_sticky && !clr_sticky) |=> ovf_sticky); // R10
endmodule

bind simd_half_alu simd_half_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_code    (op_code),
    .clr_sticky (clr_sticky),
    .result     (result),
    .ovf_pulse  (ovf_pulse),
    .ovf_sticky (ovf_sticky)
);

// File: tb/test_simd_half_alu.sv
module test_simd_half_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        clr_sticky = 1'b0;
    logic [31:0] result;
    logic        ovf_pulse;
    logic        ovf_sticky;

    int n_checks = 0;
    int n_fail   = 0;
    bit exp_sticky = 1'b0;

    always #4 clk = ~clk;

    simd_half_alu i_simd_half_alu (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .op_code    (op_code),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .clr_sticky (clr_sticky),
        .result     (result),
        .ovf_pulse  (ovf_pulse),
        .ovf_sticky (ovf_sticky)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string fam_tag(input logic [3:0] op);
        case (op[3:2])
            2'd0:    return op[1] ? "R4" : "R3";
            2'd1:    return "R5";
            2'd2:    return "R6";
            default: return "R7";
        endcase
    endfunction

    // Arithmetic reference model, built from the requirements
    task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output bit ov);
        longint x, y, v;
        longint m = longint'(op[0]);
        r  = '0;
        ov = 1'b0;
        case (op[3:2])
            2'd0: for (int l = 0; l < 2; l++) begin
                x = longint'(a[16*l +: 16]);
                y = longint'(b[16*l +: 16]);
                v = op[1] ? x - y : x + y;
                if (v > 65535 || v < 0) begin
                    ov = 1'b1;
                    if (op[0]) v = (v < 0) ? 0 : 65535;
                end
                r[16*l +: 16] = v[15:0];
            end
            2'd1: for (int l = 0; l < 4; l++) begin
                x = longint'(a[8*l +: 8]);
                y = longint'(b[8*l +: 8]);
                v = ((op[1] ? x - y : x + y) + m) >>> 1;
                r[8*l +: 8] = v[7:0];
            end
            2'd2: for (int l = 0; l < 2; l++) begin
                x = longint'($signed(a[16*l +: 16]));
                y = longint'($signed(b[16*l +: 16]));
                v = ((op[1] ? x - y : x + y) + m) >>> 1;
                r[16*l +: 16] = v[15:0];
            end
            default: begin
                x = longint'($signed(a));
                y = longint'($signed(b));
                v = ((op[1] ? x - y : x + y) + m) >>> 1;
                r = v[31:0];
            end
        endcase
    endtask

    // Drive at a falling edge, sample at the next falling edge
    task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input bit clr);
        logic [31:0] er;
        bit          eo;
        model(op, a, b, er, eo);
        op_code = op; opnd_a = a; opnd_b = b; in_valid = 1'b1; clr_sticky = clr;
        @(negedge clk);
        in_valid = 1'b0; clr_sticky = 1'b0;
        if (clr) exp_sticky = 1'b0;
        else     exp_sticky = exp_sticky | eo;
        check(result == er, fam_tag(op), longint'(result), longint'(er));
        check(ovf_pulse == eo, (op[3:2] == 2'd0) ? fam_tag(op) : "R8",
              longint'(ovf_pulse), longint'(eo));
        check(ovf_sticky == exp_sticky, "R10", longint'(ovf_sticky), longint'(exp_sticky));
    endtask

    function automatic logic [31:0] corner(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_8000;
            3: return 32'h7FFF_7FFF;
            4: return 32'h0001_0001;
            5: return 32'h807F_01FE;
            6: return 32'hFFFF_0000;
            default: return 32'h1234_5678;
        endcase
    endfunction

    initial begin : watchdog
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check(result == 32'h0 && !ovf_pulse && !ovf_sticky, "R1",
              longint'({result, ovf_pulse, ovf_sticky}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(result == 32'h0 && !ovf_pulse && !ovf_sticky, "R1",
              longint'({result, ovf_pulse, ovf_sticky}), 0);

        // R2 field decode swept over all codes and a corner grid
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run(4'(op), corner(i), corner(j), 1'b0);

        // random pairs for every code
        for (int op = 0; op < 16; op++)
            for (int n = 0; n < 100; n++)
                run(4'(op), $urandom, $urandom, 1'b0);

        // R9: idle edge holds result, no pulse
        run(4'd1, 32'hFFFF_0001, 32'h0001_0001, 1'b0);
        held = result;
        @(negedge clk);
        check(result == held, "R9", longint'(result), longint'(held));
        check(!ovf_pulse, "R9", longint'(ovf_pulse), 0);

        // R10: sticky stays through idle, then clear alone
        check(ovf_sticky, "R10", longint'(ovf_sticky), 1);
        clr_sticky = 1'b1;
        @(negedge clk);
        clr_sticky = 1'b0;
        exp_sticky = 1'b0;
        check(!ovf_sticky, "R10", longint'(ovf_sticky), 0);

        // R10: clear together with a clamping overflow, clear wins
        run(4'd3, 32'h0000_0000, 32'h0001_0000, 1'b1);
        // R4 boundary: equal lanes do not borrow
        run(4'd3, 32'h1234_ABCD, 32'h1234_ABCD, 1'b0);
        // R3 boundary: sum exactly 0xFFFF does not overflow
        run(4'd1, 32'hFFFE_8000, 32'h0001_7FFF, 1'b0);
        // R7 extremes
        run(4'd13, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0);
        run(4'd15, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule